// File: doc/BRIEF.md
# Decade Timebase Prescaler

This block turns a fast system clock into a sample-rate clock enable whose division ratio steps through the 1-2-5 sequence used for oscilloscope timebases: 1, 2, 5, 10, 20, 50, 100 and so on, by decades. A small first counter divides by 1, 2, 5 or 10. Its overflow pulse is the count enable for a chain of divide-by-ten counters, and each of those adds one decade of range. The output is a single-cycle enable strobe in the system clock domain, not a derived clock. Downstream sampling logic advances on it.

Every counter runs upward from a preset value and reloads that preset on its own overflow. No counter decodes a terminal count and then resets. The parameter `N_DECADES` sets the number of decade counters. The strobe is taken from the overflow of the counter that the ratio index selects, and it is registered before it leaves the block. A change of the ratio index reloads every counter in the same clock edge. Because of this, the first period after the change is a full period at the new ratio.

Top module: `tbase_prescaler`

## Requirements
- R1: The ratio index encodes the division ratio as follows. Index 0 gives 1. For any index i ≥ 1, let j = i-1. The ratio is mantissa × 10^(j/3), using integer division, where the mantissa is 2, 5 or 10 for j%3 equal to 0, 1 or 2. So indices 1, 2, 3, 4, 5 and 6 give 2, 5, 10, 20, 50 and 100.
- R2: While the index is held, `sample_en` is asserted exactly once every R clock cycles, where R is the selected ratio.
- R3: For any ratio above 1, each `sample_en` pulse is exactly one clock cycle wide.
- R4: At index 0, `sample_en` is high on every clock cycle.
- R5: Each decade counter advances only on the overflow pulse of the stage before it and reloads its preset on its own overflow. Ratios of 20 and above therefore have exact periods.
- R6: An index above 3+3·N_DECADES selects the largest ratio, 10^(N_DECADES+1).
- R7: While `rst` is high, `sample_en` stays low. After the last clock edge with `rst` high, the first strobe comes R edges later.
- R8: At the edge where a new index is first seen, every counter reloads and no strobe is produced. The next strobe follows R_new edges after that edge, so no period is ever shorter than the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock used by the block |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | SEL_W = clog2(4+3·N_DECADES) | Encoded 1-2-5 ratio index |
| sample_en | output | 1 | Registered single-cycle sample enable strobe |

## Verification
The hardest case to reach from the ports is an index change on the exact cycle before the edge where the old ratio would have produced its strobe. The suppressed pulse and the full new period can only be seen there. The stimulus waits for one strobe at ratio 10. It then counts nine cycles and changes the index on the ninth, then checks that no strobe appears and that the next one arrives a full ratio-20 period after the change edge. A second change, made in the middle of a long ratio-100 period, shows that the new ratio's count starts from the change edge and not from the old phase.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;
  // preset for a ten-state count ending at all-ones
  localparam cnt_t DECADE_PRESET = cnt_t'((1 << CNT_W) - 10);
endpackage

// File: rtl/tbp_preset_counter.sv
module tbp_preset_counter
  import tbp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic en,
  input  cnt_t preset,
  output logic ovf
);
  cnt_t cnt_q;

  assign ovf = en && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst || reload)  cnt_q <= preset;
    else if (en)        cnt_q <= (cnt_q == '1) ? preset : cnt_q + cnt_t'(1);
  end

  // R5: overflow reloads the preset rather than wrapping to zero
  a_r5_preset_on_ovf: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q == '1 && !reload) |=> (cnt_q == $past(preset)));

  // R5: the count never drops below its preset while the ratio is steady
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    !reload |-> (cnt_q >= preset));
endmodule

// File: rtl/tbp_ratio_decode.sv
module tbp_ratio_decode
  import tbp_pkg::*;
#(
  parameter int N_DECADES = 3,
  parameter int SEL_W     = 4,
  parameter int DW        = 2
) (
  input  logic [SEL_W-1:0] ratio_sel,
  output cnt_t             first_preset,
  output logic [DW-1:0]    dec_idx
);
  localparam int MAX_IDX = 3 + 3 * N_DECADES;

  always_comb begin
    int idx;
    int mant;
    int dec;
    idx = int'(ratio_sel);
    if (idx > MAX_IDX) idx = MAX_IDX;
    if (idx == 0) begin
      mant = 1;
      dec  = 0;
    end else begin
      dec = (idx - 1) / 3;
      case ((idx - 1) % 3)
        0:       mant = 2;
        1:       mant = 5;
        default: mant = 10;
      endcase
    end
    first_preset = cnt_t'((1 << CNT_W) - mant);
    dec_idx      = DW'(dec);
  end
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
  import tbp_pkg::*;
#(
  parameter int N_DECADES  = 3,
  localparam int NUM_RATIO = 4 + 3 * N_DECADES,
  localparam int SEL_W     = $clog2(NUM_RATIO),
  localparam int DW        = (N_DECADES > 0) ? $clog2(N_DECADES + 1) : 1,
  localparam int MAX_IDX   = NUM_RATIO - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             sample_en
);
  logic [SEL_W-1:0]   sel_q;
  logic               reload;
  cnt_t               first_preset;
  logic [DW-1:0]      dec_idx;
  logic [N_DECADES:0] stage_ovf;
  logic               strobe_q;

  assign reload = (ratio_sel != sel_q);

  tbp_ratio_decode #(.N_DECADES(N_DECADES), .SEL_W(SEL_W), .DW(DW)) u_decode (
    .ratio_sel    (ratio_sel),
    .first_preset (first_preset),
    .dec_idx      (dec_idx)
  );

  // first stage: divide by 1, 2, 5 or 10, free running
  tbp_preset_counter u_first (
    .clk    (clk),
    .rst    (rst),
    .reload (reload),
    .en     (1'b1),
    .preset (first_preset),
    .ovf    (stage_ovf[0])
  );

  // decade chain: each stage counts overflows of the one before
  for (genvar g = 1; g <= N_DECADES; g++) begin : g_decade
    tbp_preset_counter u_dec (
      .clk    (clk),
      .rst    (rst),
      .reload (reload),
      .en     (stage_ovf[g-1]),
      .preset (DECADE_PRESET),
      .ovf    (stage_ovf[g])
    );
  end

  always_ff @(posedge clk) begin
    sel_q <= ratio_sel;
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= stage_ovf[dec_idx] && !reload;
  end

  assign sample_en = strobe_q;

  // R1: index 1 maps to a divide-by-2 first stage with no decades
  a_r1_index_one: assert property (@(posedge clk) disable iff (rst)
    (int'(ratio_sel) == 1) |-> (first_preset == cnt_t'(14) && dec_idx == '0));

  // R3: strobe is one cycle wide for every ratio above 1
  a_r3_one_wide: assert property (@(posedge clk) disable iff (rst)
    (sample_en && sel_q != '0) |=> !sample_en);

  // R4: divide-by-1 strobes on every cycle
  a_r4_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (ratio_sel == '0 && sel_q == '0) |=> sample_en);

  // R6: indices at or past the top map to the full decade chain
  a_r6_clamp: assert property (@(posedge clk) disable iff (rst)
    (int'(ratio_sel) >= MAX_IDX) |-> (dec_idx == DW'(N_DECADES) && first_preset == DECADE_PRESET));

  // R7: no strobe straight out of reset
  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> !sample_en);

  // R8: the edge that sees a new index produces no strobe
  a_r8_quiet_on_change: assert property (@(posedge clk) disable iff (rst)
    reload |=> !sample_en);
endmodule

// File: tb/tbase_prescaler_bench.sv
`timescale 1ns/1ps
module tbase_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ratio_sel = 4'd3;
  logic       sample_en;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  tbase_prescaler #(.N_DECADES(3)) u_tbase_prescaler (
    .clk       (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .sample_en (sample_en)
  );

  // index, expected ratio (per R1 / R6 with three decades)
  localparam int NV = 10;
  localparam int TBL [NV][2] = '{
    '{0, 1}, '{1, 2}, '{2, 5}, '{3, 10}, '{4, 20},
    '{5, 50}, '{6, 100}, '{9, 1000}, '{12, 10000}, '{15, 10000}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_strobe(output int n, input int limit);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_en && n < limit);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    int n;
    string tag;
    // reset state (R7)
    repeat (3) @(negedge clk);
    check(sample_en == 1'b0, "R7 reset low", int'(sample_en), 0);
    rst = 1'b0;
    wait_strobe(n, 100);
    check(n == 10, "R7 first strobe after reset", n, 10);

    // table walk: first delay after change, then two steady periods
    for (int v = 0; v < NV; v++) begin
      int r;
      r = TBL[v][1];
      if (TBL[v][0] > 12)      tag = "R6";
      else if (TBL[v][0] == 0) tag = "R4";
      else if (r >= 20)        tag = "R5";
      else                     tag = "R1";
      ratio_sel = 4'(TBL[v][0]);
      wait_strobe(n, r + 10);
      check(n == r + 1, {tag, " R8 first period after change"}, n, r + 1);
      wait_strobe(n, r + 10);
      check(n == r, {tag, " period"}, n, r);
      wait_strobe(n, r + 10);
      check(n == r, "R2 steady period", n, r);
    end

    // reset mid-run at ratio 5 (R7)
    ratio_sel = 4'd2;
    wait_strobe(n, 20);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(sample_en == 1'b0, "R7 low during reset", int'(sample_en), 0);
    end
    rst = 1'b0;
    wait_strobe(n, 20);
    check(n == 5, "R7 first strobe after reset", n, 5);

    // change in the middle of a long period (R8)
    ratio_sel = 4'd6;
    wait_strobe(n, 200);
    repeat (30) @(negedge clk);
    ratio_sel = 4'd2;
    wait_strobe(n, 20);
    check(n == 6, "R8 mid-period change", n, 6);

    // change on the cycle before a due strobe (R8, R3)
    ratio_sel = 4'd3;
    wait_strobe(n, 30);
    wait_strobe(n, 30);
    @(negedge clk);
    check(sample_en == 1'b0, "R3 pulse width", int'(sample_en), 0);
    repeat (8) @(negedge clk);
    ratio_sel = 4'd4;
    wait_strobe(n, 40);
    check(n == 21, "R8 change before due strobe", n, 21);
    wait_strobe(n, 40);
    check(n == 20, "R2 period after change", n, 20);

    finish_run();
  end
endmodule